// File: doc/BRIEF.md
# Banked ROM/RAM Address Translator

This block is the purely combinational address path of a bank-switching cartridge controller. It takes a 16-bit program-bus address and a 13-bit pattern-bus address. Using the bank numbers and mode fields held by a separate configuration unit, it produces the physical program-ROM address, the work-RAM address with its select, and the physical pattern-memory address. The pattern path does not know whether the access is a read or a write, so a writable pattern memory sees the same mapping in both directions.

The program bus is split into three regions: a 16K-paged ROM window in the upper half of the space, a work-RAM window just below it, and unmapped space. When the RAM is disabled, its window is also unmapped. The block steers the returned read data from ROM or RAM and forces it to zero for unmapped accesses. The number of 16K program pages, the number of 4K pattern pages and the RAM size are parameters and must be powers of two. Bank numbers larger than the fitted memory wrap by masking.

Top module: `banked_addr_xlate`

## Requirements
- R1: The low 12 bits of `chr_addr` always equal `ppu_addr[11:0]`. For `ppu_addr` 0x0000–0x0FFF, the page in `chr_addr[CHR_AW-1:12]` is `chr_bank_lo` with bit 0 cleared when `chr_split`=0 (paired 8K mode), and `chr_bank_lo` unchanged when `chr_split`=1.
- R2: For `ppu_addr` 0x1000–0x1FFF, the page is `chr_bank_lo` with bit 0 set when `chr_split`=0, and `chr_bank_hi` when `chr_split`=1.
- R3: The pattern page is the selected bank modulo `CHR_PAGES`. With the default of 16 pages this means its low 4 bits.
- R4: For `cpu_addr` 0x8000–0xBFFF, the page in `prg_rom_addr[PRG_AW-1:14]` depends on `prg_mode`. For codes 0 and 1 (32K mode) it is `prg_bank` with bit 0 cleared. For code 2 it is page 0. For code 3 it is `prg_bank`. `prg_rom_addr[13:0]` equals `cpu_addr[13:0]`.
- R5: For `cpu_addr` 0xC000–0xFFFF, the page is `prg_bank` with bit 0 set for codes 0 and 1, `prg_bank` for code 2, and the final page `PRG_PAGES`-1 for code 3.
- R6: The program page is taken modulo `PRG_PAGES` (8 by default).
- R7: `ram_sel` is 1 exactly when `cpu_addr` is in 0x6000–0x7FFF and `ram_en`=1. `ram_addr` is the offset from 0x6000 modulo `RAM_BYTES`.
- R8: `unmapped` is 1 for every program address that selects neither ROM nor RAM, and `cpu_rdata` is then 0.
- R9: `cpu_rdata` equals `rom_rdata` when `prg_rom_sel`=1 and `ram_rdata` when `ram_sel`=1.
- R10: Exactly one of `prg_rom_sel`, `ram_sel` and `unmapped` is 1 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | Program-bus address |
| ppu_addr | input | 13 | Pattern-bus address |
| prg_mode | input | 2 | Program banking mode code |
| chr_split | input | 1 | 0: paired 8K pattern mode, 1: two independent 4K pages |
| chr_bank_lo | input | CHR_BANK_W | Pattern bank for the lower half (and the pair in 8K mode) |
| chr_bank_hi | input | CHR_BANK_W | Pattern bank for the upper half in 4K mode |
| prg_bank | input | PRG_BANK_W | Program bank number |
| ram_en | input | 1 | Work-RAM window enable |
| rom_rdata | input | DW | Data from program ROM |
| ram_rdata | input | DW | Data from work RAM |
| prg_rom_addr | output | PRG_AW | Physical program-ROM address |
| prg_rom_sel | output | 1 | Program access targets ROM |
| ram_addr | output | RAM_AW | Work-RAM address |
| ram_sel | output | 1 | Program access targets RAM |
| unmapped | output | 1 | Program access hits nothing |
| cpu_rdata | output | DW | Read data returned to the program bus |
| chr_addr | output | CHR_AW | Physical pattern-memory address |

## Verification
The pattern path is driven at addresses in both halves with bank values whose bit 0 is 0 and 1, under both pattern modes. This separates the forced bit-0 pairing from a passed-through bank. Every program mode code is applied at both window halves, with the bank both odd and even. This separates the 32K pairing, page 0, the programmed bank and the hardwired last page. Banks above the fitted page count show whether masking wraps them. Sweeping addresses around 0x6000, 0x8000 and the window edges, with RAM enabled and disabled, tells apart the ROM, RAM and zero-read regions and the data steering.

// File: rtl/banked_xlate_pkg.sv
package banked_xlate_pkg;

   typedef enum logic [1:0] {
      PRG_WIDE_A    = 2'd0,
      PRG_WIDE_B    = 2'd1,
      PRG_FIX_FIRST = 2'd2,
      PRG_FIX_LAST  = 2'd3
   } prg_mode_e;

   typedef enum logic {
      CHR_PAIRED = 1'b0,
      CHR_SPLIT  = 1'b1
   } chr_mode_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_RAM  = 2'd1,
      TGT_ROM  = 2'd2
   } cpu_tgt_e;

   localparam int unsigned CPU_AW    = 16;
   localparam int unsigned PPU_AW    = 13;
   localparam int unsigned PRG_OFS_W = 14;
   localparam int unsigned CHR_OFS_W = 12;
   localparam int unsigned RAM_WIN   = 8192;

endpackage

// File: rtl/banked_chr_map.sv
module banked_chr_map
   import banked_xlate_pkg::*;
#(
   parameter int unsigned BANK_W = 5,
   parameter int unsigned PAGES  = 16
) (
   input  logic [PPU_AW-1:0]                       ppu_addr,
   input  chr_mode_e                               mode,
   input  logic [BANK_W-1:0]                       bank_lo,
   input  logic [BANK_W-1:0]                       bank_hi,
   output logic [$clog2(PAGES)+CHR_OFS_W-1:0]      phys_addr
);
   localparam int unsigned PAGE_W = $clog2(PAGES);

   logic              upper_half;
   logic [BANK_W-1:0] sel_bank;
   logic [PAGE_W-1:0] page;

   assign upper_half = ppu_addr[CHR_OFS_W];

   always_comb begin
      if (!upper_half) begin
         if (mode == CHR_SPLIT) sel_bank = bank_lo;
         else                   sel_bank = {bank_lo[BANK_W-1:1], 1'b0};
      end else begin
         if (mode == CHR_SPLIT) sel_bank = bank_hi;
         else                   sel_bank = {bank_lo[BANK_W-1:1], 1'b1};
      end
   end

   generate
      if (BANK_W > PAGE_W) begin : g_wrap
         logic unused_bank_hi_bits;
         assign unused_bank_hi_bits = ^sel_bank[BANK_W-1:PAGE_W];
         assign page = sel_bank[PAGE_W-1:0];
      end else if (BANK_W == PAGE_W) begin : g_exact
         assign page = sel_bank;
      end else begin : g_widen
         assign page = {{(PAGE_W-BANK_W){1'b0}}, sel_bank};
      end
   endgenerate

   assign phys_addr = {page, ppu_addr[CHR_OFS_W-1:0]};

endmodule

// File: rtl/banked_prg_map.sv
module banked_prg_map
   import banked_xlate_pkg::*;
#(
   parameter int unsigned BANK_W = 4,
   parameter int unsigned PAGES  = 8
) (
   input  logic                                    upper_half,
   input  logic [PRG_OFS_W-1:0]                    offset,
   input  prg_mode_e                               mode,
   input  logic [BANK_W-1:0]                       bank,
   output logic [$clog2(PAGES)+PRG_OFS_W-1:0]      phys_addr
);
   localparam int unsigned PAGE_W = $clog2(PAGES);
   localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGES - 1);

   logic [PAGE_W-1:0] bank_m;
   logic [PAGE_W-1:0] page;

   generate
      if (BANK_W > PAGE_W) begin : g_wrap
         logic unused_bank_hi_bits;
         assign unused_bank_hi_bits = ^bank[BANK_W-1:PAGE_W];
         assign bank_m = bank[PAGE_W-1:0];
      end else if (BANK_W == PAGE_W) begin : g_exact
         assign bank_m = bank;
      end else begin : g_widen
         assign bank_m = {{(PAGE_W-BANK_W){1'b0}}, bank};
      end
   endgenerate

   generate
      if (PAGE_W > 1) begin : g_multi
         always_comb begin
            unique case (mode)
               PRG_WIDE_A, PRG_WIDE_B:
                  page = {bank_m[PAGE_W-1:1], upper_half};
               PRG_FIX_FIRST:
                  page = upper_half ? bank_m : '0;
               default:
                  page = upper_half ? LAST_PAGE : bank_m;
            endcase
         end
      end else begin : g_single
         always_comb begin
            unique case (mode)
               PRG_WIDE_A, PRG_WIDE_B: page = upper_half;
               PRG_FIX_FIRST:          page = upper_half ? bank_m : '0;
               default:                page = upper_half ? LAST_PAGE : bank_m;
            endcase
         end
      end
   endgenerate

   assign phys_addr = {page, offset};

endmodule

// File: rtl/banked_cpu_decode.sv
module banked_cpu_decode
   import banked_xlate_pkg::*;
#(
   parameter int unsigned RAM_BYTES = 8192,
   parameter int unsigned DW        = 8
) (
   input  logic [CPU_AW-1:0]              cpu_addr,
   input  logic                           ram_en,
   input  logic [DW-1:0]                  rom_rdata,
   input  logic [DW-1:0]                  ram_rdata,
   output logic                           rom_sel,
   output logic                           ram_sel,
   output logic                           unmapped,
   output logic [$clog2(RAM_BYTES)-1:0]   ram_addr,
   output logic [DW-1:0]                  rdata
);
   localparam int unsigned RAM_AW = $clog2(RAM_BYTES);

   cpu_tgt_e tgt;

   always_comb begin
      if (cpu_addr[15])                              tgt = TGT_ROM;
      else if (cpu_addr[15:13] == 3'b011 && ram_en)  tgt = TGT_RAM;
      else                                           tgt = TGT_NONE;
   end

   assign rom_sel  = (tgt == TGT_ROM);
   assign ram_sel  = (tgt == TGT_RAM);
   assign unmapped = (tgt == TGT_NONE);

   generate
      if (RAM_BYTES == RAM_WIN) begin : g_full_ram
         assign ram_addr = cpu_addr[12:0];
      end else begin : g_mirrored_ram
         logic unused_mirror_bits;
         assign unused_mirror_bits = ^cpu_addr[12:RAM_AW];
         assign ram_addr = cpu_addr[RAM_AW-1:0];
      end
   endgenerate

   always_comb begin
      unique case (tgt)
         TGT_ROM: rdata = rom_rdata;
         TGT_RAM: rdata = ram_rdata;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/banked_addr_xlate.sv
module banked_addr_xlate
   import banked_xlate_pkg::*;
#(
   parameter int unsigned PRG_PAGES  = 8,
   parameter int unsigned PRG_BANK_W = 4,
   parameter int unsigned CHR_PAGES  = 16,
   parameter int unsigned CHR_BANK_W = 5,
   parameter int unsigned RAM_BYTES  = 8192,
   parameter int unsigned DW         = 8,
   localparam int unsigned PRG_AW    = $clog2(PRG_PAGES) + 14,
   localparam int unsigned CHR_AW    = $clog2(CHR_PAGES) + 12,
   localparam int unsigned RAM_AW    = $clog2(RAM_BYTES)
) (
   input  logic [15:0]             cpu_addr,
   input  logic [12:0]             ppu_addr,
   input  logic [1:0]              prg_mode,
   input  logic                    chr_split,
   input  logic [CHR_BANK_W-1:0]   chr_bank_lo,
   input  logic [CHR_BANK_W-1:0]   chr_bank_hi,
   input  logic [PRG_BANK_W-1:0]   prg_bank,
   input  logic                    ram_en,
   input  logic [DW-1:0]           rom_rdata,
   input  logic [DW-1:0]           ram_rdata,
   output logic [PRG_AW-1:0]       prg_rom_addr,
   output logic                    prg_rom_sel,
   output logic [RAM_AW-1:0]       ram_addr,
   output logic                    ram_sel,
   output logic                    unmapped,
   output logic [DW-1:0]           cpu_rdata,
   output logic [CHR_AW-1:0]       chr_addr
);

   generate
      if (PRG_PAGES < 2 || (PRG_PAGES & (PRG_PAGES - 1)) != 0) begin : g_bad_prg_pages
         $error("PRG_PAGES must be a power of two of at least 2");
      end
      if (CHR_PAGES < 2 || (CHR_PAGES & (CHR_PAGES - 1)) != 0) begin : g_bad_chr_pages
         $error("CHR_PAGES must be a power of two of at least 2");
      end
      if (RAM_BYTES < 2 || RAM_BYTES > RAM_WIN || (RAM_BYTES & (RAM_BYTES - 1)) != 0) begin : g_bad_ram
         $error("RAM_BYTES must be a power of two between 2 and the 8K window");
      end
      if (PRG_BANK_W < 1 || CHR_BANK_W < 2 || DW < 1) begin : g_bad_widths
         $error("bank and data widths are too small");
      end
   endgenerate

   prg_mode_e prg_mode_q;
   chr_mode_e chr_mode_q;

   assign prg_mode_q = prg_mode_e'(prg_mode);
   assign chr_mode_q = chr_mode_e'(chr_split);

   banked_chr_map #(
      .BANK_W (CHR_BANK_W),
      .PAGES  (CHR_PAGES)
   ) u_chr_map (
      .ppu_addr  (ppu_addr),
      .mode      (chr_mode_q),
      .bank_lo   (chr_bank_lo),
      .bank_hi   (chr_bank_hi),
      .phys_addr (chr_addr)
   );

   banked_prg_map #(
      .BANK_W (PRG_BANK_W),
      .PAGES  (PRG_PAGES)
   ) u_prg_map (
      .upper_half (cpu_addr[14]),
      .offset     (cpu_addr[13:0]),
      .mode       (prg_mode_q),
      .bank       (prg_bank),
      .phys_addr  (prg_rom_addr)
   );

   banked_cpu_decode #(
      .RAM_BYTES (RAM_BYTES),
      .DW        (DW)
   ) u_cpu_decode (
      .cpu_addr  (cpu_addr),
      .ram_en    (ram_en),
      .rom_rdata (rom_rdata),
      .ram_rdata (ram_rdata),
      .rom_sel   (prg_rom_sel),
      .ram_sel   (ram_sel),
      .unmapped  (unmapped),
      .ram_addr  (ram_addr),
      .rdata     (cpu_rdata)
   );

endmodule

// File: rtl/banked_addr_xlate_chk.sv
module banked_addr_xlate_chk #(
   parameter int unsigned PRG_PAGES = 8,
   parameter int unsigned CHR_PAGES = 16,
   parameter int unsigned DW        = 8,
   localparam int unsigned PRG_AW   = $clog2(PRG_PAGES) + 14,
   localparam int unsigned CHR_AW   = $clog2(CHR_PAGES) + 12
) (
   input logic [15:0]        cpu_addr,
   input logic [12:0]        ppu_addr,
   input logic [1:0]         prg_mode,
   input logic               chr_split,
   input logic               ram_en,
   input logic [DW-1:0]      rom_rdata,
   input logic [DW-1:0]      ram_rdata,
   input logic [PRG_AW-1:0]  prg_rom_addr,
   input logic               prg_rom_sel,
   input logic               ram_sel,
   input logic               unmapped,
   input logic [DW-1:0]      cpu_rdata,
   input logic [CHR_AW-1:0]  chr_addr
);

   always_comb begin
      p_offset_kept_r1: assert (chr_addr[11:0] == ppu_addr[11:0])
         else $error("pattern offset altered");
      if (!chr_split) begin
         p_pair_bit_r2: assert (chr_addr[12] == ppu_addr[12])
            else $error("paired mode page bit 0 does not follow half");
      end
      if (prg_rom_sel) begin
         p_prg_offset_r4: assert (prg_rom_addr[13:0] == cpu_addr[13:0])
            else $error("program offset altered");
      end
      if (prg_mode == 2'd2 && cpu_addr[15:14] == 2'b10) begin
         p_fix_first_r4: assert (prg_rom_addr[PRG_AW-1:14] == '0)
            else $error("fix-first low half not page 0");
      end
      if (prg_mode == 2'd3 && cpu_addr[15:14] == 2'b11) begin
         p_fix_last_r5: assert (&prg_rom_addr[PRG_AW-1:14])
            else $error("fix-last high half not final page");
      end
      if (ram_sel) begin
         p_ram_gate_r7: assert (ram_en && cpu_addr[15:13] == 3'b011)
            else $error("RAM selected outside its enabled window");
      end
      if (unmapped) begin
         p_zero_read_r8: assert (cpu_rdata == '0)
            else $error("unmapped read not zero");
      end
      if (prg_rom_sel) begin
         p_rom_data_r9: assert (cpu_rdata == rom_rdata)
            else $error("ROM data not returned");
      end
      if (ram_sel) begin
         p_ram_data_r9: assert (cpu_rdata == ram_rdata)
            else $error("RAM data not returned");
      end
      p_one_target_r10: assert ($countones({prg_rom_sel, ram_sel, unmapped}) == 1)
         else $error("program target not unique");
   end

endmodule

bind banked_addr_xlate banked_addr_xlate_chk #(
   .PRG_PAGES (PRG_PAGES),
   .CHR_PAGES (CHR_PAGES),
   .DW        (DW)
) u_chk (
   .cpu_addr     (cpu_addr),
   .ppu_addr     (ppu_addr),
   .prg_mode     (prg_mode),
   .chr_split    (chr_split),
   .ram_en       (ram_en),
   .rom_rdata    (rom_rdata),
   .ram_rdata    (ram_rdata),
   .prg_rom_addr (prg_rom_addr),
   .prg_rom_sel  (prg_rom_sel),
   .ram_sel      (ram_sel),
   .unmapped     (unmapped),
   .cpu_rdata    (cpu_rdata),
   .chr_addr     (chr_addr)
);

// File: tb/banked_addr_xlate_tb.sv
module banked_addr_xlate_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [15:0] cpu_addr;
   logic [12:0] ppu_addr;
   logic [1:0]  prg_mode;
   logic        chr_split;
   logic [4:0]  chr_bank_lo;
   logic [4:0]  chr_bank_hi;
   logic [3:0]  prg_bank;
   logic        ram_en;
   logic [7:0]  rom_rdata;
   logic [7:0]  ram_rdata;
   logic [16:0] prg_rom_addr;
   logic        prg_rom_sel;
   logic [12:0] ram_addr;
   logic        ram_sel;
   logic        unmapped;
   logic [7:0]  cpu_rdata;
   logic [15:0] chr_addr;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   banked_addr_xlate u_dut (
      .cpu_addr     (cpu_addr),
      .ppu_addr     (ppu_addr),
      .prg_mode     (prg_mode),
      .chr_split    (chr_split),
      .chr_bank_lo  (chr_bank_lo),
      .chr_bank_hi  (chr_bank_hi),
      .prg_bank     (prg_bank),
      .ram_en       (ram_en),
      .rom_rdata    (rom_rdata),
      .ram_rdata    (ram_rdata),
      .prg_rom_addr (prg_rom_addr),
      .prg_rom_sel  (prg_rom_sel),
      .ram_addr     (ram_addr),
      .ram_sel      (ram_sel),
      .unmapped     (unmapped),
      .cpu_rdata    (cpu_rdata),
      .chr_addr     (chr_addr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Reference models written from the requirements
   function automatic int exp_chr(int a, int split, int lo, int hi);
      int b;
      if (a < 'h1000) b = split ? lo : (lo & ~1);
      else            b = split ? hi : (lo | 1);
      return (b % 16) * 'h1000 + (a % 'h1000);
   endfunction

   function automatic int exp_prg(int a, int m, int bank);
      int mb = bank % 8;
      bit up = (a >= 'hC000);
      int p;
      case (m)
         0, 1: p = up ? (mb | 1) : (mb & ~1);
         2:    p = up ? mb : 0;
         default: p = up ? 7 : mb;
      endcase
      return p * 'h4000 + (a % 'h4000);
   endfunction

   task automatic drive_chr(int a, int split, int lo, int hi);
      @(posedge clk);
      ppu_addr = 13'(a); chr_split = 1'(split);
      chr_bank_lo = 5'(lo); chr_bank_hi = 5'(hi);
      @(negedge clk);
   endtask

   task automatic drive_cpu(int a, int m, int bank, int en);
      @(posedge clk);
      cpu_addr = 16'(a); prg_mode = 2'(m); prg_bank = 4'(bank); ram_en = 1'(en);
      @(negedge clk);
   endtask

   task automatic t_reset_state;
      chk("R8", "idle unmapped", int'(unmapped), 1);
      chk("R8", "idle rdata", int'(cpu_rdata), 0);
      chk("R1", "idle chr_addr", int'(chr_addr), 0);
   endtask

   task automatic t_chr_paired;
      for (int lo = 2; lo <= 3; lo++) begin
         drive_chr('h0123, 0, lo, 9);
         chk("R1", "paired low half", int'(chr_addr), exp_chr('h0123, 0, lo, 9));
         drive_chr('h1ABC, 0, lo, 9);
         chk("R2", "paired high half", int'(chr_addr), exp_chr('h1ABC, 0, lo, 9));
      end
   endtask

   task automatic t_chr_split;
      drive_chr('h0FFF, 1, 7, 10);
      chk("R1", "split low half", int'(chr_addr), exp_chr('h0FFF, 1, 7, 10));
      drive_chr('h1000, 1, 7, 10);
      chk("R2", "split high half", int'(chr_addr), exp_chr('h1000, 1, 7, 10));
   endtask

   task automatic t_chr_wrap;
      drive_chr('h0456, 1, 'h15, 'h1E);
      chk("R3", "wrap low", int'(chr_addr), exp_chr('h0456, 1, 'h15, 'h1E));
      drive_chr('h1456, 1, 'h15, 'h1E);
      chk("R3", "wrap high", int'(chr_addr), exp_chr('h1456, 1, 'h15, 'h1E));
      drive_chr('h1456, 0, 'h1C, 0);
      chk("R3", "wrap paired", int'(chr_addr), exp_chr('h1456, 0, 'h1C, 0));
   endtask

   task automatic t_prg_modes;
      for (int m = 0; m < 4; m++) begin
         for (int b = 4; b <= 5; b++) begin
            drive_cpu('h8ACE, m, b, 0);
            chk("R4", $sformatf("low half mode %0d bank %0d", m, b),
                int'(prg_rom_addr), exp_prg('h8ACE, m, b));
            drive_cpu('hFFFC, m, b, 0);
            chk("R5", $sformatf("high half mode %0d bank %0d", m, b),
                int'(prg_rom_addr), exp_prg('hFFFC, m, b));
         end
      end
   endtask

   task automatic t_prg_wrap;
      drive_cpu('hBFFF, 3, 'hB, 0);
      chk("R6", "wrap fix-last low", int'(prg_rom_addr), exp_prg('hBFFF, 3, 'hB));
      drive_cpu('hC000, 2, 'hE, 0);
      chk("R6", "wrap fix-first high", int'(prg_rom_addr), exp_prg('hC000, 2, 'hE));
      drive_cpu('h8000, 0, 'hF, 0);
      chk("R6", "wrap 32K low", int'(prg_rom_addr), exp_prg('h8000, 0, 'hF));
   endtask

   task automatic t_ram_window;
      drive_cpu('h6000, 3, 0, 1);
      chk("R7", "ram_sel at base", int'(ram_sel), 1);
      chk("R7", "ram_addr at base", int'(ram_addr), 0);
      drive_cpu('h7ABC, 3, 0, 1);
      chk("R7", "ram_addr offset", int'(ram_addr), 'h1ABC);
      drive_cpu('h7ABC, 3, 0, 0);
      chk("R7", "ram_sel disabled", int'(ram_sel), 0);
      chk("R8", "disabled ram unmapped", int'(unmapped), 1);
      chk("R8", "disabled ram rdata", int'(cpu_rdata), 0);
   endtask

   task automatic t_unmapped_edges;
      int addrs[4] = '{'h0000, 'h4020, 'h5FFF, 'h7FFF};
      int exp_sel[4] = '{0, 0, 0, 1};
      foreach (addrs[i]) begin
         drive_cpu(addrs[i], 3, 0, 1);
         chk("R7", $sformatf("ram_sel @%0h", addrs[i]), int'(ram_sel), exp_sel[i]);
         chk("R8", $sformatf("unmapped @%0h", addrs[i]), int'(unmapped), 1 - exp_sel[i]);
         chk("R10", $sformatf("one target @%0h", addrs[i]),
             int'(prg_rom_sel) + int'(ram_sel) + int'(unmapped), 1);
      end
      drive_cpu('h8000, 3, 0, 1);
      chk("R10", "rom at 0x8000", int'(prg_rom_sel), 1);
      chk("R10", "rom excludes ram", int'(ram_sel), 0);
   endtask

   task automatic t_read_mux;
      @(posedge clk); rom_rdata = 8'hA5; ram_rdata = 8'h3C;
      drive_cpu('hC123, 0, 0, 1);
      chk("R9", "rom data", int'(cpu_rdata), 'hA5);
      drive_cpu('h6123, 0, 0, 1);
      chk("R9", "ram data", int'(cpu_rdata), 'h3C);
      drive_cpu('h2000, 0, 0, 1);
      chk("R8", "unmapped data", int'(cpu_rdata), 0);
   endtask

   initial begin
      cpu_addr = '0; ppu_addr = '0; prg_mode = '0; chr_split = 1'b0;
      chr_bank_lo = '0; chr_bank_hi = '0; prg_bank = '0; ram_en = 1'b0;
      rom_rdata = 8'h5A; ram_rdata = 8'h77;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_chr_paired();
      t_chr_split();
      t_chr_wrap();
      t_prg_modes();
      t_prg_wrap();
      t_ram_window();
      t_unmapped_edges();
      t_read_mux();
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule